// File: doc/BRIEF.md
# Multiplexed bus cycle sequencer

This block produces the external pin timing for one machine cycle of an 8-bit processor with a 16-bit address. The low address byte and the data byte share one 8-bit port, which is split here into an output value, an input value and an output enable. A caller starts a cycle with a one-clock request that carries the cycle kind, the I/O-versus-memory choice, the address and the write data. The sequencer then steps through its clock states. It drives the address-latch pulse, the high address byte, the shared port, the active-low read and write strobes, the I/O flag and the two status bits. It returns the read data together with a one-clock done pulse.

A slow target stretches the cycle through the ready input. The sequencer samples ready on falling clock edges and adds whole clocks in which every line keeps its value. A halt request parks the bus in a quiet state. A hold input takes the bus off the pins between cycles. While reset is held, every output is undriven.

Top module: `bus_cycle_seq`

## Requirements
- R1: In the first clock of a cycle (the address clock), the shared port is driven with address bits 7..0 and `addr_hi` carries bits 15..8. `ale` is high during the first half of that clock and low during the second half. Neither strobe is active in that clock.
- R2: The request kind is coded as {s1,s0}: 2'b10 read, 2'b01 write, 2'b11 opcode fetch, 2'b00 halt. This code appears on `s1`/`s0` from the address clock onward and stays unchanged for the whole cycle. `io_m` equals the request's I/O flag (1 = I/O, 0 = memory), except that an opcode fetch always shows `io_m`=0.
- R3: For a read or a fetch, `rd_n` is low in every clock after the address clock up to the last data clock, and the port is released (`ad_oe`=0) in those clocks. `ad_in` is captured into `rd_data` on the rising edge that ends the low phase of `rd_n`.
- R4: For a write, `wr_n` is low in every clock after the address clock up to the last data clock, and the port is driven with the write data in those clocks.
- R5: Without wait states, a read or a write takes three clocks and a fetch takes four. In the fourth clock of a fetch both strobes are high and the port is released. `done` is high for exactly the one clock that follows the last clock of the cycle, and `rd_data` is valid in that clock.
- R6: `ready` is sampled on the falling edge inside the second clock and on the falling edge of each wait clock. If the sampled value is low, one whole wait clock is added. In a wait clock the strobe, address, port value and status keep their values.
- R7: `rd_n` and `wr_n` are never low together, and neither is low in the address clock.
- R8: A halt request puts the bus in a halt state. In that state `io_m`, `s1` and `s0` are driven to 0. The high address, the port and the strobes are undriven. The state lasts until the next request, which then starts a normal cycle.
- R9: While `hold` is high and no cycle is running, the high address, the port, the strobes and `io_m`/status are undriven and no request is started. A cycle already running when `hold` rises runs to completion.
- R10: While `rst_n` is low, every output enable is 0. After reset the sequencer is idle with both strobes high and driven.
- R11: A request seen while a cycle is running is ignored. It does not start a further cycle and it does not change the address of the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold | input | 1 | Bus request from another master |
| req | input | 1 | Start a cycle (sampled while idle or halted) |
| req_kind | input | 2 | Cycle kind, same code as {s1,s0} |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| ready | input | 1 | Target ready, sampled on falling edges |
| ad_in | input | 8 | Value seen on the shared port |
| ale | output | 1 | Address latch pulse |
| addr_hi | output | 8 | Address bits 15..8 |
| addr_hi_oe | output | 1 | Drive enable for `addr_hi` |
| ad_out | output | 8 | Value driven on the shared port |
| ad_oe | output | 1 | Drive enable for the shared port |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Drive enable for `rd_n` and `wr_n` |
| io_m | output | 1 | 1 = I/O, 0 = memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| status_oe | output | 1 | Drive enable for `io_m`, `s1`, `s0` |
| rd_data | output | 8 | Captured read data |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions check on every clock that the two strobes never overlap and never fall in the address clock, and that the port is driven in the address clock and released under a read strobe. They also check that status and address stay frozen while a strobe stays low, that the halt state shows zero status with the strobes released, and that every enable is low in reset. The absolute cycle lengths, the position of each added wait clock against the ready level, and the captured read value need known stimulus, so only the bench scenarios show them. The same holds for a request ignored mid-cycle and a hold that defers the next cycle.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            req,
  input  logic [1:0]      req_kind,
  input  logic            req_io,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            ready,
  input  logic [DW-1:0]   ad_in,
  output logic            ale,
  output logic [AW-DW-1:0] addr_hi,
  output logic            addr_hi_oe,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic            rd_n,
  output logic            wr_n,
  output logic            strobe_oe,
  output logic            io_m,
  output logic            s1,
  output logic            s0,
  output logic            status_oe,
  output logic [DW-1:0]   rd_data,
  output logic            done
);
  localparam logic [1:0] K_HALT  = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_FETCH = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_HALT} st_t;

  st_t           st;
  logic [1:0]    kind_q;
  logic          io_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          rdy_s;
  logic          t1_seen;

  logic idle_like, start, data_ph, is_rd, is_wr, bus_free, addr_phase;

  assign idle_like  = (st == S_IDLE) || (st == S_HALT);
  assign start      = idle_like && req && !hold;
  assign data_ph    = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign is_rd      = kind_q[1];
  assign is_wr      = (kind_q == K_WRITE);
  assign bus_free   = hold && idle_like;
  assign addr_phase = (st == S_T1);

  assign ale        = rst_n && addr_phase && !t1_seen;
  assign addr_hi    = addr_q[AW-1:DW];
  assign addr_hi_oe = rst_n && !bus_free && (st != S_HALT);
  assign ad_out     = addr_phase ? addr_q[DW-1:0] : wd_q;
  assign ad_oe      = rst_n && (addr_phase || (data_ph && is_wr));
  assign rd_n       = !(data_ph && is_rd);
  assign wr_n       = !(data_ph && is_wr);
  assign strobe_oe  = rst_n && !bus_free && (st != S_HALT);
  assign io_m       = io_q;
  assign s1         = kind_q[1];
  assign s0         = kind_q[0];
  assign status_oe  = rst_n && !bus_free;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s   <= 1'b0;
      t1_seen <= 1'b0;
    end else begin
      rdy_s   <= ready;
      t1_seen <= addr_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= K_HALT;
      io_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE, S_HALT: begin
          if (start) begin
            kind_q <= req_kind;
            if (req_kind == K_HALT) begin
              io_q <= 1'b0;
              st   <= S_HALT;
            end else begin
              io_q   <= req_io && (req_kind != K_FETCH);
              addr_q <= req_addr;
              wd_q   <= req_wdata;
              st     <= S_T1;
            end
          end
        end
        S_T1: st <= S_T2;
        S_T2, S_TW: st <= rdy_s ? S_T3 : S_TW;
        S_T3: begin
          if (is_rd) rd_data <= ad_in;
          if (kind_q == K_FETCH) begin
            st <= S_T4;
          end else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_T4: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module bus_cycle_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_phase,
  input logic             ad_oe,
  input logic [DW-1:0]    ad_out,
  input logic [AW-DW-1:0] addr_hi,
  input logic             addr_hi_oe,
  input logic             rd_n,
  input logic             wr_n,
  input logic             strobe_oe,
  input logic             io_m,
  input logic             s1,
  input logic             s0,
  input logic             status_oe
);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7
  no_strobe_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> (rd_n && wr_n));

  // R1
  addr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> ad_oe);

  // R3
  read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R2
  status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable({io_m, s1, s0}));

  // R6
  read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> ($stable(addr_hi) && $stable(ad_oe)));

  // R6
  write_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(ad_out) && $stable(addr_hi)));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_oe && status_oe) |-> (!io_m && !s1 && !s0 && !addr_hi_oe && !ad_oe));

  // R10
  always_comb begin
    if (!rst_n) begin
      reset_float_chk: assert (!ad_oe && !addr_hi_oe && !strobe_oe && !status_oe);
    end
  end
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .ad_oe(ad_oe),
  .ad_out(ad_out), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
  .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe), .io_m(io_m),
  .s1(s1), .s0(s0), .status_oe(status_oe)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  logic clk = 1'b0;
  logic rst_n, hold, req, req_io, ready;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, ad_in;
  logic ale, addr_hi_oe, ad_oe, rd_n, wr_n, strobe_oe, io_m, s1, s0, status_oe, done;
  logic [7:0] addr_hi, ad_out, rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .req(req), .req_kind(req_kind),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .ad_in(ad_in), .ale(ale), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
    .ad_out(ad_out), .ad_oe(ad_oe), .rd_n(rd_n), .wr_n(wr_n),
    .strobe_oe(strobe_oe), .io_m(io_m), .s1(s1), .s0(s0),
    .status_oe(status_oe), .rd_data(rd_data), .done(done)
  );

  // kind[37:36] io[35] addr[34:19] wdata[18:11] rdata[10:3] waits[2:0]
  localparam logic [37:0] VEC [6] = '{
    {2'b10, 1'b0, 16'h1234, 8'h00, 8'h5A, 3'd0},
    {2'b01, 1'b1, 16'h00C7, 8'hA5, 8'h00, 3'd1},
    {2'b11, 1'b0, 16'h8001, 8'h00, 8'h3E, 3'd2},
    {2'b10, 1'b1, 16'h0042, 8'h00, 8'hC3, 3'd3},
    {2'b01, 1'b0, 16'hFF00, 8'h81, 8'h00, 3'd0},
    {2'b11, 1'b1, 16'h2468, 8'h00, 8'h76, 3'd0}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic run_cycle(input logic [37:0] v);
    logic [1:0] k;
    logic exp_io, rdk, wrk;
    int waits;
    k = v[37:36];
    waits = int'(v[2:0]);
    exp_io = v[35] && (k != 2'b11);
    rdk = k[1];
    wrk = (k == 2'b01);
    req_kind = k; req_io = v[35]; req_addr = v[34:19]; req_wdata = v[18:11];
    ad_in = v[10:3]; ready = (waits == 0); req = 1'b1;
    tick;
    req = 1'b0;
    check("R1 ale first half", {31'd0, ale}, 32'd1);
    check("R1 port address", {23'd0, ad_oe, ad_out}, {23'd0, 1'b1, v[26:19]});
    check("R1 high address", {24'd0, addr_hi}, {24'd0, v[34:27]});
    check("R7 strobes idle in address clock", {30'd0, rd_n, wr_n}, 32'd3);
    check("R2 status code", {29'd0, io_m, s1, s0}, {29'd0, exp_io, k});
    #2;
    check("R1 ale second half", {31'd0, ale}, 32'd0);
    tick;
    check("R3 R4 strobes data clock", {30'd0, rd_n, wr_n}, {30'd0, !rdk, !wrk});
    if (wrk) check("R4 write data", {23'd0, ad_oe, ad_out}, {23'd0, 1'b1, v[18:11]});
    else     check("R3 port released", {31'd0, ad_oe}, 32'd0);
    for (int w = 0; w < waits; w++) begin
      tick;
      check("R6 wait clock held", {12'd0, rd_n, wr_n, ad_oe, addr_hi, io_m, s1, s0, done},
            {12'd0, !rdk, !wrk, wrk, v[34:27], exp_io, k, 1'b0});
      if (w == waits - 1) ready = 1'b1;
    end
    tick;
    check("R5 last data clock", {29'd0, rd_n, wr_n, done}, {29'd0, !rdk, !wrk, 1'b0});
    tick;
    if (k == 2'b11) begin
      check("R5 fetch fourth clock", {28'd0, rd_n, wr_n, ad_oe, done}, {28'd0, 4'b1100});
      tick;
    end
    check("R5 done pulse", {30'd0, done, rd_n}, 32'd3);
    if (rdk) check("R3 read data", {24'd0, rd_data}, {24'd0, v[10:3]});
    tick;
    check("R5 done one clock", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hold = 1'b0; req = 1'b0; req_kind = 2'b00; req_io = 1'b0;
    req_addr = '0; req_wdata = '0; ready = 1'b1; ad_in = '0;
    tick; tick;
    check("R10 enables low in reset", {27'd0, ale, ad_oe, addr_hi_oe, strobe_oe, status_oe}, 32'd0);
    rst_n = 1'b1;
    tick;
    check("R10 idle after reset", {27'd0, strobe_oe, rd_n, wr_n, ad_oe, done}, {27'd0, 5'b11100});

    for (int i = 0; i < 6; i++) run_cycle(VEC[i]);

    // R8 halt
    req_kind = 2'b00; req_io = 1'b1; req = 1'b1;
    tick;
    req = 1'b0;
    check("R8 halt state", {26'd0, status_oe, io_m, s1, s0, strobe_oe, addr_hi_oe},
          {26'd0, 6'b100000});
    tick; tick;
    check("R8 halt persists", {29'd0, status_oe, strobe_oe, ad_oe}, {29'd0, 3'b100});
    run_cycle({2'b10, 1'b0, 16'h5511, 8'h00, 8'h99, 3'd1});

    // R9 hold while idle
    hold = 1'b1; req_kind = 2'b10; req_io = 1'b0; req_addr = 16'hABCD; req = 1'b1; ready = 1'b1;
    tick; tick; tick;
    check("R9 bus released under hold", {27'd0, addr_hi_oe, ad_oe, strobe_oe, status_oe, ale}, 32'd0);
    hold = 1'b0;
    tick;
    req = 1'b0;
    check("R9 cycle starts after hold", {15'd0, ale, addr_hi, ad_out}, {15'd0, 1'b1, 16'hABCD});
    for (int i = 0; i < 6 && !done; i++) tick;
    check("R9 deferred cycle completes", {31'd0, done}, 32'd1);
    tick;

    // R9 hold raised mid-cycle
    req_kind = 2'b01; req_addr = 16'h3300; req_wdata = 8'h44; req = 1'b1;
    tick;
    req = 1'b0;
    tick;
    hold = 1'b1;
    check("R9 running write keeps strobe", {30'd0, wr_n, strobe_oe}, 32'd1);
    for (int i = 0; i < 6 && !done; i++) tick;
    check("R9 running cycle finishes", {31'd0, done}, 32'd1);
    tick;
    check("R9 released after finish", {30'd0, addr_hi_oe, strobe_oe}, 32'd0);
    hold = 1'b0;
    tick;

    // R11 request during a cycle
    req_kind = 2'b01; req_addr = 16'h7710; req_wdata = 8'h0F; req = 1'b1;
    tick;
    req = 1'b0;
    tick;
    req_kind = 2'b10; req_addr = 16'hBEEF; req = 1'b1;
    tick;
    req = 1'b0;
    check("R11 address unchanged mid-cycle", {24'd0, addr_hi}, 32'h77);
    tick;
    check("R11 first cycle done", {31'd0, done}, 32'd1);
    tick;
    check("R11 no extra cycle", {26'd0, ale, rd_n, wr_n, ad_oe, done, 1'b0}, {26'd0, 6'b011000});
    check("R11 address kept", {24'd0, addr_hi}, 32'h77);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule